// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block sits between a controller's transmit data line and the enable of a bus line driver. A low level on the transmit line asks for a dominant bus and a high level asks for a recessive bus. The guard passes that request to the driver only while normal mode is active. It stops the bus from being held dominant for too long. It also stops the driver from turning on at the moment normal mode begins while the transmit line is still low, for example when that line is shorted to ground.

The transmit level first passes through a two-flop synchroniser. A microsecond tick paces the two timers. The dominant timer measures how long the synchronised line has stayed low while the driver is enabled. When it reaches `TMO_TICKS`, the guard forces the driver recessive and raises a time-out flag. The release timer measures how long the line has stayed high without a break. The driver is enabled again only after the line has been high for more than `REL_TICKS` ticks. This rule applies after a time-out and also at every entry into normal mode.

The controller runs in four named states:
- `GS_OFF`: normal mode is inactive.
- `GS_ARM`: normal mode has just been entered and the guard waits for release.
- `GS_RUN`: the driver follows the transmit line.
- `GS_TMO`: a time-out has happened and the guard waits for release.

The transitions are:
- OFF→ARM when normal mode becomes active.
- ARM→RUN when the release condition is met.
- RUN→TMO when the dominant time-out expires.
- TMO→RUN when the release condition is met.
- ARM, RUN or TMO → OFF when normal mode drops.

Top module: `txd_dom_guard`

## Requirements
- R1: After reset both outputs are 0, the guard is in `GS_OFF`, and the synchronised transmit level reads high (recessive).
- R2: In `GS_RUN`, `drv_dom` is the inverse of `txd_raw` delayed through two flops. A change of `txd_raw` reaches `drv_dom` 2 clock edges later and not 1.
- R3: One cycle after `norm_act` is sampled low, `drv_dom` and `tmo_flag` are both 0. A low `txd_raw` outside normal mode never drives the bus.
- R4: In `GS_RUN`, when the synchronised line has been low for `TMO_TICKS` ticks, the next edge forces `drv_dom` to 0 and sets `tmo_flag` to 1.
- R5: The dominant timer restarts from zero whenever the synchronised line is high. Consecutive low periods that are each shorter than the time-out never cause a time-out.
- R6: Both timers advance only on cycles with `us_tick`=1. Without ticks, a low line never times out.
- R7: After a time-out, the driver is enabled again only after the line has been high for more than `REL_TICKS` consecutive ticks. A shorter high pulse followed by a low level keeps `drv_dom` at 0.
- R8: `tmo_flag` stays 1 from the time-out until the release condition moves the guard to `GS_RUN`, or until normal mode is left. While the flag is 1, `drv_dom` is 0.
- R9: At every entry into normal mode, `drv_dom` stays 0 until the line has been high for more than `REL_TICKS` consecutive ticks. High time that began before entry counts. A line held low at entry keeps the driver off indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_raw | input | 1 | Asynchronous transmit level; 0 requests dominant |
| norm_act | input | 1 | 1 while normal mode is active |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| drv_dom | output | 1 | Driver command; 1 drives dominant, 0 recessive |
| tmo_flag | output | 1 | 1 while the guard is blocked after a dominant time-out |

## Verification
The timing counts from the edge after an input changes:
- A change of `txd_raw` reaches `drv_dom` two edges later.
- With a tick every cycle, a time-out appears `TMO_TICKS`+3 edges after the line falls.
- A release appears `REL_TICKS`+4 edges after the line rises.
- A drop of `norm_act` clears both outputs one edge later.

The driver task drives inputs at the falling clock edge. It files each expectation with the absolute cycle on which that result is due, worked out from these counts. The monitor compares outputs at the falling edge of that exact cycle. Checks are placed one cycle before and one cycle at each transition, so an output that arrives early or late is reported.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [1:0] {
        GS_OFF = 2'd0,
        GS_ARM = 2'd1,
        GS_RUN = 2'd2,
        GS_TMO = 2'd3
    } guard_state_t;

endpackage

// File: rtl/dtg_sync2.sv
module dtg_sync2 #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= RESET_VAL;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dtg_tick_window.sv
module dtg_tick_window #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIM_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIM_C);

    // R6: the window can only complete on a tick
    a_r6_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(tick));

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard
    import dtg_pkg::*;
#(
    parameter int TMO_TICKS = 40000,
    parameter int REL_TICKS = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_raw,
    input  logic norm_act,
    input  logic us_tick,
    output logic drv_dom,
    output logic tmo_flag
);
    localparam int REL_LIMIT = REL_TICKS + 1;

    guard_state_t state_q, state_d;
    logic txd_s;
    logic dom_clr, dom_done;
    logic hi_clr, hi_done;

    dtg_sync2 #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(txd_raw),
        .q_sync (txd_s)
    );

    // dominant timer: runs only while driving and the line is low
    assign dom_clr = txd_s || (state_q != GS_RUN);

    dtg_tick_window #(.LIMIT(TMO_TICKS)) u_dom_win (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (us_tick),
        .clr  (dom_clr),
        .done (dom_done)
    );

    // release timer: continuous high time of the line
    assign hi_clr = !txd_s;

    dtg_tick_window #(.LIMIT(REL_LIMIT)) u_rel_win (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (us_tick),
        .clr  (hi_clr),
        .done (hi_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_OFF: if (norm_act)       state_d = GS_ARM;
            GS_ARM: if (!norm_act)      state_d = GS_OFF;
                    else if (hi_done)   state_d = GS_RUN;
            GS_RUN: if (!norm_act)      state_d = GS_OFF;
                    else if (dom_done)  state_d = GS_TMO;
            GS_TMO: if (!norm_act)      state_d = GS_OFF;
                    else if (hi_done)   state_d = GS_RUN;
            default:                    state_d = GS_OFF;
        endcase
    end

    always_comb begin
        drv_dom  = 1'b0;
        tmo_flag = 1'b0;
        unique case (state_q)
            GS_OFF: ;
            GS_ARM: ;
            GS_RUN: drv_dom  = !txd_s;
            GS_TMO: tmo_flag = 1'b1;
            default: ;
        endcase
    end

    // R3: leaving normal mode silences both outputs on the next cycle
    a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !norm_act |=> (!drv_dom && !tmo_flag));

    // R8: the time-out flag always blocks the driver
    a_r8_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |-> !drv_dom);

    // R7: a release inside normal mode follows a completed high window
    a_r7_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tmo_flag) && $past(norm_act)) |-> $past(hi_done));

    // R9: the first cycle after entry never drives
    a_r9_entry_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(norm_act) |=> !drv_dom);

    // R4: a time-out can only start from a completed dominant window
    a_r4_tmo_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(dom_done));

endmodule

// File: tb/txd_dom_guard_tb_top.sv
module txd_dom_guard_tb_top;

    localparam int TMO = 40;
    localparam int REL = 10;

    typedef struct {
        int    due;
        bit    drv;
        bit    tmo;
        string tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd_raw = 1'b1;
    logic norm_act = 1'b0;
    logic us_tick = 1'b1;
    logic drv_dom, tmo_flag;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    exp_item_t exp_q[$];

    always #4 clk = ~clk;

    txd_dom_guard #(.TMO_TICKS(TMO), .REL_TICKS(REL)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .txd_raw (txd_raw),
        .norm_act(norm_act),
        .us_tick (us_tick),
        .drv_dom (drv_dom),
        .tmo_flag(tmo_flag)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // driver side: file an expectation d cycles from now, sorted by due cycle
    task automatic expect_at(input int d, input bit drv, input bit tmo, input string tag);
        exp_item_t it;
        int pos;
        it.due = cyc + d; it.drv = drv; it.tmo = tmo; it.tag = tag;
        pos = exp_q.size();
        for (int i = 0; i < exp_q.size(); i++) begin
            if (exp_q[i].due > it.due) begin pos = i; break; end
        end
        exp_q.insert(pos, it);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor side
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_item_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (it.due != cyc) begin
                n_errors++;
                $display("FAIL %s: check for cycle %0d missed (now %0d)", it.tag, it.due, cyc);
            end else if (drv_dom !== it.drv || tmo_flag !== it.tmo) begin
                n_errors++;
                $display("FAIL %s @%0d: drv_dom=%b tmo_flag=%b expected drv_dom=%b tmo_flag=%b",
                         it.tag, cyc, drv_dom, tmo_flag, it.drv, it.tmo);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        wait_cyc(20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        expect_at(1, 0, 0, "R1 reset state");
        wait_cyc(20);

        // R3: low line outside normal mode
        txd_raw = 1'b0;
        expect_at(5, 0, 0, "R3 off low");
        expect_at(30, 0, 0, "R3 off low");
        wait_cyc(40);
        txd_raw = 1'b1;
        wait_cyc(20);

        // R9 entry with line already high long; R2 latency
        norm_act = 1'b1;
        wait_cyc(5);
        txd_raw = 1'b0;
        expect_at(1, 0, 0, "R2 not after one edge");
        expect_at(2, 1, 0, "R2 dominant");
        wait_cyc(10);
        txd_raw = 1'b1;
        expect_at(1, 1, 0, "R2 still dominant");
        expect_at(2, 0, 0, "R2 recessive");
        wait_cyc(5);

        // R5 repeated low periods under the limit
        for (int k = 0; k < 4; k++) begin
            txd_raw = 1'b0;
            expect_at(31, 1, 0, "R5 long frame");
            wait_cyc(30);
            txd_raw = 1'b1;
            wait_cyc(2);
        end
        wait_cyc(20);

        // R4 time-out
        txd_raw = 1'b0;
        expect_at(42, 1, 0, "R4 before limit");
        expect_at(43, 0, 1, "R4 time-out");
        expect_at(60, 0, 1, "R8 flag held");
        wait_cyc(70);

        // R7 short high pulse does not release
        txd_raw = 1'b1;
        expect_at(10, 0, 1, "R7 short high");
        wait_cyc(5);
        txd_raw = 1'b0;
        expect_at(20, 0, 1, "R7 low after short high");
        wait_cyc(25);

        // R7/R8 release after a full high window
        txd_raw = 1'b1;
        expect_at(13, 0, 1, "R8 flag before release");
        expect_at(14, 0, 0, "R8 flag cleared");
        wait_cyc(20);
        txd_raw = 1'b0;
        expect_at(2, 1, 0, "R7 driver re-enabled");
        wait_cyc(5);

        // R3 leave normal while dominant
        norm_act = 1'b0;
        expect_at(1, 0, 0, "R3 leave while dominant");
        wait_cyc(5);

        // R9 entry with line stuck low
        norm_act = 1'b1;
        expect_at(60, 0, 0, "R9 stuck low");
        wait_cyc(70);
        txd_raw = 1'b1;
        wait_cyc(5);
        txd_raw = 1'b0;
        expect_at(10, 0, 0, "R9 short high");
        wait_cyc(20);
        txd_raw = 1'b1;
        wait_cyc(20);
        txd_raw = 1'b0;
        expect_at(2, 1, 0, "R9 enabled after window");
        wait_cyc(5);
        txd_raw = 1'b1;
        wait_cyc(20);

        // R6 no ticks, no time-out
        us_tick = 1'b0;
        txd_raw = 1'b0;
        expect_at(100, 1, 0, "R6 no ticks");
        wait_cyc(100);
        us_tick = 1'b1;
        expect_at(40, 1, 0, "R6 ticks resumed");
        expect_at(41, 0, 1, "R6 time-out after ticks");
        wait_cyc(50);

        // R8 leaving normal clears the flag
        norm_act = 1'b0;
        expect_at(1, 0, 0, "R8 flag cleared off");
        wait_cyc(5);
        txd_raw = 1'b1;
        wait_cyc(5);

        wait (exp_q.size() == 0);
        wait_cyc(2);
        summary();
    end

endmodule